// File: doc/BRIEF.md
# Overlay Memory Address Mapper

This block sits between a processor core and its memory ports. It takes a 14-bit address in either program space or data space. It decides whether the access goes to on-chip memory, to the data-space control-register bank, or to one of two external 8K pages. A page register for each space controls one 8K window. Page value 0 keeps that window on chip. Values 1 and 2 send it off chip, and the page value sets external address bit 13 while the low 13 bits pass through unchanged. All other parts of both address maps stay fixed.

External accesses drive a program or data strobe. They stall the core through `ready_o` for a programmed number of wait states, counted separately for each space. Internal and control-register accesses complete in the request cycle. The requester must hold its request and address steady while `ready_o` is low.

When the mode-B strap is high, overlays in program space are disabled and the program page register is held at 0. Both page registers and both wait registers can be read and written directly. The core does not save them on an interrupt.

Top module: `ovl_mapper`

## Requirements
- R1: After a synchronous reset, both page registers and both wait registers read 0, `ready_o` is 1, and no strobe or hit flag is asserted.
- R2: Program addresses 0x0000–0x1FFF are always internal. Program addresses 0x2000–0x3FFF are internal when the program page is 0.
- R3: With program page 1 or 2, a program access in 0x2000–0x3FFF asserts `ext_pm_sel_o`. `ext_addr_o` then equals {page==2, addr[12:0]}.
- R4: Data addresses 0x0000–0x1FFF are internal when the data page is 0. With data page 1 or 2 they assert `ext_dm_sel_o`, and `ext_addr_o` equals {page==2, addr[12:0]}.
- R5: Data addresses 0x2000–0x3FDF are always internal (`int_hit_o`). Data addresses 0x3FE0–0x3FFF assert `mmr_hit_o` instead.
- R6: A write of a value of 3 or more to a page register is ignored, and the register keeps its old value.
- R7: While `mode_b_i` is 1, the program page register reads 0 from the next cycle on. Any write to it stores 0, and program addresses 0x2000–0x3FFF decode as internal.
- R8: An external access whose wait register holds N keeps `ready_o` low for exactly N cycles and then raises it. The strobe is asserted for N+1 cycles. Internal and control-register accesses have `ready_o` high in the request cycle.
- R9: At most one of `int_hit_o`, `mmr_hit_o`, `ext_pm_sel_o` and `ext_dm_sel_o` is high at a time. With no request none is high, and `ext_addr_o` is 0 whenever no strobe is asserted.
- R10: The configuration select code picks the register: 0 is the program page, 1 the data page, 2 the program wait count, and 3 the data wait count. A wait register takes all 3 bits of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_b_i | input | 1 | Mode-B strap; disables program overlays |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_sel_i | input | 2 | Register select (0 pm page, 1 dm page, 2 pm wait, 3 dm wait) |
| cfg_wdata_i | input | 3 | Configuration write data |
| req_i | input | 1 | Access request, held while `ready_o` is low |
| space_i | input | 1 | 0 = program space, 1 = data space |
| addr_i | input | 14 | Processor address |
| ready_o | output | 1 | Access completes in this cycle when high |
| int_hit_o | output | 1 | Access goes to on-chip memory |
| mmr_hit_o | output | 1 | Access goes to the control-register bank |
| ext_pm_sel_o | output | 1 | External program memory strobe |
| ext_dm_sel_o | output | 1 | External data memory strobe |
| ext_addr_o | output | 14 | External address |
| pm_page_o | output | 2 | Program page register |
| dm_page_o | output | 2 | Data page register |
| pm_wait_o | output | 3 | Program wait-state count |
| dm_wait_o | output | 3 | Data wait-state count |

## Verification
The assertions check the following on every cycle:
- the one-hot property of the target flags;
- that neither page register ever holds 3;
- that the program page is cleared under mode B;
- that internal hits never stall;
- that a strobe is still present after each stall cycle, and that no stall run exceeds the largest wait count;
- that the low external address bits follow the request.

Only the bench scenarios can show the rest:
- the exact stall length for each programmed N;
- the mapping of each page value to A13 at the window edges;
- that illegal page writes leave the old value in place.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int ADDR_W  = 14;
    localparam int LOW_W   = ADDR_W - 1;
    localparam int PAGE_W  = 2;
    localparam int WAIT_W  = 3;
    localparam int NUM_PG  = 3;
    localparam logic [ADDR_W-1:0] MMR_BASE = 14'h3FE0;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_INT  = 2'd1,
        TGT_MMR  = 2'd2,
        TGT_EXT  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        CFG_PM_PAGE = 2'd0,
        CFG_DM_PAGE = 2'd1,
        CFG_PM_WAIT = 2'd2,
        CFG_DM_WAIT = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        tgt_e              tgt;
        logic              is_pm;
        logic [ADDR_W-1:0] xaddr;
    } map_s;

    function automatic map_s classify(
        input logic              req,
        input logic              space_dm,
        input logic [ADDR_W-1:0] addr,
        input logic [PAGE_W-1:0] pm_page,
        input logic [PAGE_W-1:0] dm_page
    );
        map_s              m;
        logic              in_win;
        logic [PAGE_W-1:0] pg;
        m.tgt   = TGT_NONE;
        m.is_pm = ~space_dm;
        m.xaddr = '0;
        in_win  = space_dm ? ~addr[ADDR_W-1] : addr[ADDR_W-1];
        pg      = space_dm ? dm_page : pm_page;
        if (req) begin
            if (in_win && (pg != '0)) begin
                m.tgt   = TGT_EXT;
                m.xaddr = {(pg == PAGE_W'(2)), addr[LOW_W-1:0]};
            end else if (space_dm && (addr >= MMR_BASE)) begin
                m.tgt = TGT_MMR;
            end else begin
                m.tgt = TGT_INT;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/ovl_regs.sv
module ovl_regs
    import ovl_pkg::*;
#(
    parameter int PW = PAGE_W,
    parameter int WW = WAIT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_b,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [WW-1:0] wdata,
    output logic [PW-1:0] pm_page,
    output logic [PW-1:0] dm_page,
    output logic [WW-1:0] pm_wait,
    output logic [WW-1:0] dm_wait
);
    localparam int PG_LIMIT = NUM_PG;

    logic page_ok;
    assign page_ok = (int'(wdata) < PG_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_page <= '0;
            dm_page <= '0;
            pm_wait <= '0;
            dm_wait <= '0;
        end else begin
            if (we) begin
                unique case (cfg_sel_e'(sel))
                    CFG_PM_PAGE: if (page_ok) pm_page <= PW'(wdata);
                    CFG_DM_PAGE: if (page_ok) dm_page <= PW'(wdata);
                    CFG_PM_WAIT: pm_wait <= wdata;
                    CFG_DM_WAIT: dm_wait <= wdata;
                    default: ;
                endcase
            end
            if (mode_b) pm_page <= '0;
        end
    end
endmodule

// File: rtl/ovl_decode.sv
module ovl_decode
    import ovl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PAGE_W
) (
    input  logic          req,
    input  logic          space_dm,
    input  logic [AW-1:0] addr,
    input  logic          mode_b,
    input  logic [PW-1:0] pm_page,
    input  logic [PW-1:0] dm_page,
    output map_s          map
);
    logic [PW-1:0] pm_eff;
    assign pm_eff = mode_b ? '0 : pm_page;

    always_comb begin
        map = classify(req, space_dm, addr, pm_eff, dm_page);
    end
endmodule

// File: rtl/ovl_wait_fsm.sv
module ovl_wait_fsm
    import ovl_pkg::*;
#(
    parameter int WW = WAIT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  map_s          dec,
    input  logic [WW-1:0] pm_wait,
    input  logic [WW-1:0] dm_wait,
    output map_s          cur,
    output logic          ready
);
    logic          busy;
    logic [WW-1:0] cnt;
    map_s          held;
    logic [WW-1:0] n;
    logic          start;

    assign n     = dec.is_pm ? pm_wait : dm_wait;
    assign start = ~busy && (dec.tgt == TGT_EXT) && (n != '0);

    always_comb begin
        if (busy) begin
            cur   = held;
            ready = (cnt == '0);
        end else begin
            cur   = dec;
            ready = ~start;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            held <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= n - WW'(1);
            held <= dec;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - WW'(1);
        end
    end
endmodule

// File: rtl/ovl_mapper.sv
module ovl_mapper
    import ovl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PAGE_W,
    parameter int WW = WAIT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_b_i,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_sel_i,
    input  logic [WW-1:0] cfg_wdata_i,
    input  logic          req_i,
    input  logic          space_i,
    input  logic [AW-1:0] addr_i,
    output logic          ready_o,
    output logic          int_hit_o,
    output logic          mmr_hit_o,
    output logic          ext_pm_sel_o,
    output logic          ext_dm_sel_o,
    output logic [AW-1:0] ext_addr_o,
    output logic [PW-1:0] pm_page_o,
    output logic [PW-1:0] dm_page_o,
    output logic [WW-1:0] pm_wait_o,
    output logic [WW-1:0] dm_wait_o
);
    map_s dec_map;
    map_s cur_map;
    logic is_ext;

    ovl_regs #(.PW(PW), .WW(WW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .mode_b  (mode_b_i),
        .we      (cfg_we_i),
        .sel     (cfg_sel_i),
        .wdata   (cfg_wdata_i),
        .pm_page (pm_page_o),
        .dm_page (dm_page_o),
        .pm_wait (pm_wait_o),
        .dm_wait (dm_wait_o)
    );

    ovl_decode #(.AW(AW), .PW(PW)) u_dec (
        .req      (req_i),
        .space_dm (space_i),
        .addr     (addr_i),
        .mode_b   (mode_b_i),
        .pm_page  (pm_page_o),
        .dm_page  (dm_page_o),
        .map      (dec_map)
    );

    ovl_wait_fsm #(.WW(WW)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .dec     (dec_map),
        .pm_wait (pm_wait_o),
        .dm_wait (dm_wait_o),
        .cur     (cur_map),
        .ready   (ready_o)
    );

    assign is_ext       = (cur_map.tgt == TGT_EXT);
    assign int_hit_o    = (cur_map.tgt == TGT_INT);
    assign mmr_hit_o    = (cur_map.tgt == TGT_MMR);
    assign ext_pm_sel_o = is_ext &  cur_map.is_pm;
    assign ext_dm_sel_o = is_ext & ~cur_map.is_pm;
    assign ext_addr_o   = is_ext ? cur_map.xaddr : '0;
endmodule

// File: rtl/ovl_mapper_chk.sv
module ovl_mapper_chk #(
    parameter int AW = 14,
    parameter int PW = 2,
    parameter int WW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_b_i,
    input logic          req_i,
    input logic [AW-1:0] addr_i,
    input logic          ready_o,
    input logic          int_hit_o,
    input logic          mmr_hit_o,
    input logic          ext_pm_sel_o,
    input logic          ext_dm_sel_o,
    input logic [AW-1:0] ext_addr_o,
    input logic [PW-1:0] pm_page_o,
    input logic [PW-1:0] dm_page_o
);
    localparam int MAXW = (1 << WW) - 1;
    logic [WW:0] stall_cnt;
    logic        strobe;
    assign strobe = ext_pm_sel_o | ext_dm_sel_o;

    always_ff @(posedge clk) begin
        if (rst || ready_o) stall_cnt <= '0;
        else                stall_cnt <= stall_cnt + 1'b1;
    end

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (pm_page_o == '0 && dm_page_o == '0 && ready_o)); // R1
    AST_PAGE_LEGAL: assert property (@(posedge clk) disable iff (rst) (pm_page_o != PW'(3)) && (dm_page_o != PW'(3))); // R6
    AST_MODEB_CLEAR: assert property (@(posedge clk) disable iff (rst) mode_b_i |=> (pm_page_o == '0)); // R7
    AST_INT_NO_STALL: assert property (@(posedge clk) disable iff (rst) (int_hit_o || mmr_hit_o) |-> ready_o); // R8
    AST_STALL_STROBE: assert property (@(posedge clk) disable iff (rst) !ready_o |=> strobe); // R8
    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst) int'(stall_cnt) <= MAXW); // R8
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst) $onehot0({int_hit_o, mmr_hit_o, ext_pm_sel_o, ext_dm_sel_o})); // R9
    AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst) !strobe |-> (ext_addr_o == '0)); // R9
    AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst) (strobe && req_i) |-> (ext_addr_o[AW-2:0] == addr_i[AW-2:0])); // R3
endmodule

bind ovl_mapper ovl_mapper_chk #(.AW(AW), .PW(PW), .WW(WW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_b_i     (mode_b_i),
    .req_i        (req_i),
    .addr_i       (addr_i),
    .ready_o      (ready_o),
    .int_hit_o    (int_hit_o),
    .mmr_hit_o    (mmr_hit_o),
    .ext_pm_sel_o (ext_pm_sel_o),
    .ext_dm_sel_o (ext_dm_sel_o),
    .ext_addr_o   (ext_addr_o),
    .pm_page_o    (pm_page_o),
    .dm_page_o    (dm_page_o)
);

// File: tb/tb_ovl_mapper.sv
module tb_ovl_mapper;
    logic        clk = 1'b0;
    logic        rst;
    logic        mode_b_i;
    logic        cfg_we_i;
    logic [1:0]  cfg_sel_i;
    logic [2:0]  cfg_wdata_i;
    logic        req_i;
    logic        space_i;
    logic [13:0] addr_i;
    logic        ready_o, int_hit_o, mmr_hit_o, ext_pm_sel_o, ext_dm_sel_o;
    logic [13:0] ext_addr_o;
    logic [1:0]  pm_page_o, dm_page_o;
    logic [2:0]  pm_wait_o, dm_wait_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] m_pm_pg = 0, m_dm_pg = 0;
    logic [2:0] m_pm_w = 0, m_dm_w = 0;
    logic       m_modeb = 0;

    always #2 clk = ~clk;

    ovl_mapper dut (.*);

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // target code: 0 none, 1 internal, 2 control register, 3 external
    function automatic int exp_tgt(input bit dm, input logic [13:0] a);
        logic [1:0] pg;
        bit win;
        pg  = dm ? m_dm_pg : (m_modeb ? 2'd0 : m_pm_pg);
        win = dm ? !a[13] : a[13];
        if (win && pg != 0) return 3;
        if (dm && a >= 14'h3FE0) return 2;
        return 1;
    endfunction

    function automatic logic [13:0] exp_xa(input bit dm, input logic [13:0] a);
        logic [1:0] pg;
        pg = dm ? m_dm_pg : m_pm_pg;
        return {pg == 2'd2, a[12:0]};
    endfunction

    function automatic int dut_tgt();
        if (ext_pm_sel_o || ext_dm_sel_o) return 3;
        if (mmr_hit_o) return 2;
        if (int_hit_o) return 1;
        return 0;
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [2:0] d);
        @(negedge clk);
        cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 0;
        case (sel)
            2'd0: if (d < 3) m_pm_pg = m_modeb ? 2'd0 : d[1:0];
            2'd1: if (d < 3) m_dm_pg = d[1:0];
            2'd2: m_pm_w = d;
            default: m_dm_w = d;
        endcase
        #1;
        chk(pm_page_o == m_pm_pg, "R6 R10 pm page", pm_page_o, m_pm_pg);
        chk(dm_page_o == m_dm_pg, "R6 R10 dm page", dm_page_o, m_dm_pg);
        chk(pm_wait_o == m_pm_w && dm_wait_o == m_dm_w, "R10 waits",
            {pm_wait_o, dm_wait_o}, {m_pm_w, m_dm_w});
    endtask

    task automatic access(input bit dm, input logic [13:0] a);
        int et, stalls, strobes, expn;
        bit bad_sel;
        logic [13:0] ex;
        et = exp_tgt(dm, a);
        ex = exp_xa(dm, a);
        expn = (et == 3) ? int'(dm ? m_dm_w : m_pm_w) : 0;
        stalls = 0; strobes = 0; bad_sel = 0;
        @(negedge clk);
        req_i = 1; space_i = dm; addr_i = a;
        forever begin
            #1;
            if (ext_pm_sel_o || ext_dm_sel_o) strobes++;
            if (dut_tgt() != et) bad_sel = 1;
            if (et == 3 && (ext_addr_o != ex || ext_pm_sel_o != !dm)) bad_sel = 1;
            if (ready_o || stalls > 20) break;
            @(negedge clk);
            stalls++;
        end
        chk(!bad_sel, dm ? "R4 R5 R9 data decode" : "R2 R3 R7 program decode",
            dut_tgt(), et);
        if (et == 3) chk(ext_addr_o == ex, "R3 R4 ext address", ext_addr_o, ex);
        chk(stalls == expn, "R8 stall cycles", stalls, expn);
        if (et == 3) chk(strobes == expn + 1, "R8 strobe cycles", strobes, expn + 1);
        @(negedge clk);
        req_i = 0;
        #1;
        chk(dut_tgt() == 0 && ext_addr_o == 0, "R9 idle outputs", dut_tgt(), 0);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1 - 1, n_chk + 1);
        $finish;
    end

    initial begin
        logic [13:0] edges [6];
        void'($urandom(32'd2718));
        edges = '{14'h0000, 14'h1FFF, 14'h2000, 14'h3FDF, 14'h3FE0, 14'h3FFF};
        rst = 1; mode_b_i = 0; cfg_we_i = 0; cfg_sel_i = 0; cfg_wdata_i = 0;
        req_i = 0; space_i = 0; addr_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(pm_page_o == 0 && dm_page_o == 0 && pm_wait_o == 0 && dm_wait_o == 0,
            "R1 registers", {pm_page_o, dm_page_o}, 0);
        chk(ready_o && dut_tgt() == 0, "R1 outputs", {ready_o, dut_tgt()}, 4);

        // directed sweep: each page value over window edges
        for (int w = 0; w < 2; w++) begin
            cfg_write(2'd2, w ? 3'd3 : 3'd0);
            cfg_write(2'd3, w ? 3'd7 : 3'd0);
            for (int pg = 0; pg < 3; pg++) begin
                cfg_write(2'd0, 3'(pg));
                cfg_write(2'd1, 3'(pg));
                for (int e = 0; e < 6; e++) begin
                    access(0, edges[e]);
                    access(1, edges[e]);
                end
            end
        end

        // R6: illegal page values leave old value
        cfg_write(2'd0, 3'd1);
        cfg_write(2'd0, 3'd3);
        cfg_write(2'd1, 3'd2);
        cfg_write(2'd1, 3'd7);
        access(0, 14'h2ABC);
        access(1, 14'h0ABC);

        // R7: mode B clears program page and blocks overlay
        @(negedge clk);
        mode_b_i = 1; m_modeb = 1;
        @(negedge clk);
        m_pm_pg = 0;
        #1;
        chk(pm_page_o == 0, "R7 page cleared", pm_page_o, 0);
        cfg_write(2'd0, 3'd2);
        access(0, 14'h2000);
        access(0, 14'h3FFF);
        access(1, 14'h1000);
        @(negedge clk);
        mode_b_i = 0; m_modeb = 0;

        // random mix
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(3) == 0)
                cfg_write(2'($urandom_range(3)), 3'($urandom_range(7)));
            else
                access(1'($urandom_range(1)), 14'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule